// File: doc/BRIEF.md
# Edge-Counting Timer/Counter

This block is a 16-bit up-counter with a prescaler. It can advance on every system clock, which is timer mode. It can also advance on edges seen on one of four external capture pins, which is counter mode. Every pin goes through a two-flop synchronizer. After that, one more sample stage keeps the previous level. A rising or falling edge is found by comparing the synchronized level with that previous sample. Because of this, an external signal is only counted correctly when each high or low level lasts at least one clock period. This keeps the pin at or below half the clock frequency.

A clear feature can force the counter and prescaler to zero on a chosen edge of a chosen pin. A capture register stores the counter value on a chosen edge of a chosen pin. With the clear on the leading edge of a pulse and the capture on the trailing edge, the capture register holds the pulse width directly. One match register drives a DMA request. A four-word write port loads the configuration.

The match rule for the DMA request differs from a common alternative. The request is a level that stays high while the counter equals the match value. It is not a one-cycle event. So a match value of zero also raises the request whenever the counter sits at zero.

Top module: `tmr_edge_counter`

## Requirements
- R1: After reset, all four configuration words are zero, the counter, prescaler and capture register are zero, and the block runs in timer mode.
- R2: Timer mode uses mode code 00. With prescale value P, the counter advances once every P+1 clocks. It wraps from 0xFFFF to 0x0000.
- R3: A level change on a capture pin, applied between two clock edges, reaches the counter at the third rising clock edge after the change.
- R4: Counter mode uses control bits 1:0. Code 01 counts rising edges, 10 counts falling edges and 11 counts both edges of the selected pin. Edges on pins that are not selected are ignored.
- R5: Control bits 3:2 choose which capture pin, 0 to 3, is counted.
- R6: Control bit 4 enables the clear. Bits 6:5 choose the clear pin. Bit 7 chooses the clear edge: 0 for rising, 1 for falling. The chosen edge sets the counter and prescaler to zero.
- R7: When a clear and a count event fall in the same cycle, the counter becomes zero.
- R8: Capture-control bits 1:0 choose the capture pin, bit 2 captures on rising edges and bit 3 captures on falling edges. The capture register takes the counter value held just before that edge is applied. If the clear is on a rising edge, the capture is on the falling edge of the same pin, and the prescale is 0, a high level lasting H clocks gives a captured value of H-1.
- R9: Capture-control bits 5:4 are the match action. With 10 or 11, dma_req is high exactly while the counter equals the match word, including a match word of 0. With 00 or 01, dma_req stays low.
- R10: Write address 0 loads the count control from wr_data[7:0]. Address 1 loads the prescale value, address 2 the match word, and address 3 the capture control from wr_data[5:0]. A written value takes effect from the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cap_in | input | 4 | External capture pins, asynchronous |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | Configuration word address |
| wr_data | input | 16 | Write data |
| count_out | output | 16 | Current counter value |
| capture_out | output | 16 | Capture register |
| dma_req | output | 1 | DMA request, high while the counter equals the match word and the match action is 10 or 11 |

## Verification
The clear and the count advance can both be triggered by one edge in the same cycle. To provoke this, the bench routes both to the same pin, clears on rising edges and counts both edges. A full pulse then clears on its leading edge and counts once on its trailing edge. So the counter must read 1 after one pulse and still read 1 after a second pulse. A failure to give the clear priority shows up as 2 or more. Randomized pin activity on the other pins runs alongside. This checks that unselected inputs never leak into the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CAP_N = 4;
    localparam int SEL_W = $clog2(CAP_N);

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_RISE  = 2'b01,
        MODE_FALL  = 2'b10,
        MODE_BOTH  = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_RSVD   = 2'b01,
        ACT_SET    = 2'b10,
        ACT_TOGGLE = 2'b11
    } match_act_e;

    typedef enum logic [1:0] {
        ADDR_CTL    = 2'd0,
        ADDR_PRE    = 2'd1,
        ADDR_MATCH  = 2'd2,
        ADDR_CAPCTL = 2'd3
    } reg_addr_e;

    // count control word, 8 bits
    typedef struct packed {
        logic             clr_fall;
        logic [SEL_W-1:0] clr_sel;
        logic             clr_en;
        logic [SEL_W-1:0] cnt_sel;
        cnt_mode_e        mode;
    } cnt_ctl_t;

    // capture / match control word, 6 bits
    typedef struct packed {
        match_act_e       act;
        logic             cap_fall;
        logic             cap_rise;
        logic [SEL_W-1:0] cap_sel;
    } cap_ctl_t;

    function automatic logic edge_hit(cnt_mode_e m, logic r, logic f);
        case (m)
            MODE_RISE: return r;
            MODE_FALL: return f;
            MODE_BOTH: return r | f;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic logic act_requests(match_act_e a);
        return (a == ACT_SET) || (a == ACT_TOGGLE);
    endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= pin[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end
endmodule

// File: rtl/tmr_reg_file.sv
module tmr_reg_file
    import tmr_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [TW-1:0] wr_data,
    output cnt_ctl_t      ctl,
    output logic [TW-1:0] pre,
    output logic [TW-1:0] match,
    output cap_ctl_t      capctl
);
    localparam int CTL_W = $bits(cnt_ctl_t);
    localparam int CAP_W = $bits(cap_ctl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            pre    <= '0;
            match  <= '0;
            capctl <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CTL:    ctl    <= cnt_ctl_t'(wr_data[CTL_W-1:0]);
                ADDR_PRE:    pre    <= wr_data;
                ADDR_MATCH:  match  <= wr_data;
                ADDR_CAPCTL: capctl <= cap_ctl_t'(wr_data[CAP_W-1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          clr,
    input  logic [TW-1:0] pre,
    output logic [TW-1:0] tc
);
    logic [TW-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc <= '0;
            tc <= '0;
        end else if (tick) begin
            if (pc >= pre) begin
                pc <= '0;
                tc <= tc + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_edge_counter.sv
module tmr_edge_counter
    import tmr_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CAP_N-1:0] cap_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TW-1:0]    wr_data,
    output logic [TW-1:0]    count_out,
    output logic [TW-1:0]    capture_out,
    output logic             dma_req
);
    cnt_ctl_t         ctl;
    cap_ctl_t         capctl;
    logic [TW-1:0]    pre_q, match_q, tc_q, cap_q;
    logic [CAP_N-1:0] rise, fall;
    logic             tick, clr_ev, cap_ev;

    tmr_edge_det #(.N(CAP_N)) u_det (
        .clk(clk), .rst(rst), .pin(cap_in), .rise(rise), .fall(fall)
    );

    tmr_reg_file #(.TW(TW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctl(ctl), .pre(pre_q), .match(match_q),
        .capctl(capctl)
    );

    always_comb begin
        tick   = edge_hit(ctl.mode, rise[ctl.cnt_sel], fall[ctl.cnt_sel]);
        clr_ev = ctl.clr_en && (ctl.clr_fall ? fall[ctl.clr_sel]
                                             : rise[ctl.clr_sel]);
        cap_ev = (capctl.cap_rise && rise[capctl.cap_sel]) ||
                 (capctl.cap_fall && fall[capctl.cap_sel]);
    end

    tmr_count_core #(.TW(TW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .clr(clr_ev), .pre(pre_q),
        .tc(tc_q)
    );

    always_ff @(posedge clk) begin
        if (rst)         cap_q <= '0;
        else if (cap_ev) cap_q <= tc_q;
    end

    assign count_out   = tc_q;
    assign capture_out = cap_q;
    assign dma_req     = (tc_q == match_q) && act_requests(capctl.act);
endmodule

// File: rtl/tmr_edge_counter_chk.sv
module tmr_edge_counter_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          clr_ev,
    input logic          cap_ev,
    input logic [TW-1:0] tc,
    input logic [TW-1:0] cap_out,
    input logic          dma_req,
    input logic [TW-1:0] pre,
    input logic [TW-1:0] match
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tc == '0 && cap_out == '0 && !dma_req));

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_ev |=> (tc == '0));

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && pre == '0 && !clr_ev) |=> (tc == TW'($past(tc) + 1'b1)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr_ev) |=> $stable(tc));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap_ev |=> (cap_out == $past(tc)));

    // R9
    dma_match_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (tc == match));
endmodule

bind tmr_edge_counter tmr_edge_counter_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .clr_ev(clr_ev), .cap_ev(cap_ev),
    .tc(tc_q), .cap_out(capture_out), .dma_req(dma_req), .pre(pre_q),
    .match(match_q)
);

// File: tb/sim_tmr_edge_counter.sv
`timescale 1ns/1ps
module sim_tmr_edge_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cap_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_out, capture_out;
    logic        dma_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_edge_counter u0 (
        .clk(clk), .rst(rst), .cap_in(cap_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count_out(count_out),
        .capture_out(capture_out), .dma_req(dma_req)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int b, int h);
        cap_in[b] = 1'b1;
        hold(h);
        cap_in[b] = 1'b0;
    endtask

    // counter mode rising on pin 0 (idle), clear on pin 3 rising -> tc = 0
    task automatic freeze_clear();
        wr(2'd0, 16'h0071);
        pulse(3, 2);
        hold(5);
    endtask

    function automatic int exp_hit(int m, bit r, bit f);
        if (m == 1) return int'(r);
        if (m == 2) return int'(f);
        return int'(r | f);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        hold(3);
        rst = 1'b0;
        // R1 reset state, timer mode by default
        chk("R1 count after reset", int'(count_out), 0);
        chk("R1 capture after reset", int'(capture_out), 0);
        chk("R1 dma after reset", int'(dma_req), 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R1 R2 default timer mode runs", int'(count_out), 10);

        // R6 clear on pin 3
        freeze_clear();
        chk("R6 clear to zero", int'(count_out), 0);

        // R3 latency through synchronizer and sample stage
        cap_in[0] = 1'b1;
        @(negedge clk);
        chk("R3 no change after one edge", int'(count_out), 0);
        @(negedge clk);
        chk("R3 no change after two edges", int'(count_out), 0);
        @(negedge clk);
        chk("R3 counted at third edge", int'(count_out), 1);
        cap_in[0] = 1'b0;
        hold(4);

        // R4 unselected pins ignored
        for (int k = 0; k < 5; k++) begin
            pulse(1, 2); pulse(2, 1); hold(2);
        end
        hold(4);
        chk("R4 unselected pins ignored", int'(count_out), 1);

        // R4 falling-edge code 10
        freeze_clear();
        wr(2'd0, 16'h0072);
        pulse(0, 3);
        hold(1);
        chk("R4 falling mode ignores rise", int'(count_out), 0);
        hold(4);
        chk("R4 falling mode counts fall", int'(count_out), 1);

        // R2 prescale, random P
        for (int k = 0; k < 3; k++) begin
            int p = int'($urandom_range(1, 6));
            int n = int'($urandom_range(20, 60));
            freeze_clear();
            wr(2'd1, 16'(p));
            wr(2'd0, 16'h0000);
            repeat (n) @(posedge clk);
            @(negedge clk);
            chk("R2 prescaled count", int'(count_out), n / (p + 1));
        end
        wr(2'd1, 16'h0000);

        // R2 wrap
        freeze_clear();
        wr(2'd0, 16'h0000);
        repeat (65535) @(posedge clk);
        @(negedge clk);
        chk("R2 reaches 0xFFFF", int'(count_out), 16'hFFFF);
        @(negedge clk);
        chk("R2 wraps to zero", int'(count_out), 0);

        // R4 R5 random counter-mode activity
        for (int rnd = 0; rnd < 4; rnd++) begin
            int s = int'($urandom_range(0, 2));
            int m = int'($urandom_range(1, 3));
            int exp = 0;
            logic [2:0] prev = 3'b000;
            wr(2'd0, 16'({1'b0, 2'd3, 1'b1, 2'(s), 2'(m)}));
            pulse(3, 2);
            hold(5);
            for (int st = 0; st < 40; st++) begin
                logic [2:0] v = (st == 39) ? 3'b000 : 3'($urandom);
                exp += exp_hit(m, v[s] & ~prev[s], ~v[s] & prev[s]);
                cap_in[2:0] = v;
                prev = v;
                hold(int'($urandom_range(1, 3)));
            end
            hold(5);
            chk($sformatf("R4 R5 random pin %0d mode %0d", s, m),
                int'(count_out), exp);
        end

        // R7 clear and count on the same edge
        freeze_clear();
        wr(2'd0, 16'h005B);
        pulse(2, 3); hold(5);
        chk("R7 clear wins, one pulse", int'(count_out), 1);
        pulse(2, 3); hold(5);
        chk("R7 clear wins, two pulses", int'(count_out), 1);

        // R8 pulse width: clear on pin 1 rise, capture on pin 1 fall
        wr(2'd0, 16'h0030);
        wr(2'd3, 16'h0009);
        for (int k = 0; k < 3; k++) begin
            int h = int'($urandom_range(3, 20));
            hold(3);
            pulse(1, h);
            hold(5);
            chk("R8 pulse width capture", int'(capture_out), h - 1);
        end

        // R9 DMA request including match on zero
        freeze_clear();
        wr(2'd3, 16'h0020);
        chk("R9 set action, match zero", int'(dma_req), 1);
        wr(2'd3, 16'h0000);
        chk("R9 action 00 no request", int'(dma_req), 0);
        wr(2'd3, 16'h0010);
        chk("R9 action 01 no request", int'(dma_req), 0);
        wr(2'd3, 16'h0030);
        chk("R9 toggle action, match zero", int'(dma_req), 1);
        wr(2'd2, 16'd5);
        chk("R10 R9 match word 5 not reached", int'(dma_req), 0);
        for (int k = 0; k < 5; k++) begin
            pulse(0, 2); hold(2);
        end
        hold(4);
        chk("R9 count equals match", int'(count_out), 5);
        chk("R9 request at match", int'(dma_req), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule